// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels owns the bus when more than one of them asks for it in the same cycle. Each channel raises a level request. When the arbiter is idle and allowed to grant, it picks one requester by the active priority scheme and drives a registered one-hot grant. That grant stays in place until the channel's transfer-complete strobe is seen. Address generation, byte counting and bus cycles belong to the channels and are not part of this block.

A single 16-bit control word sets the priority scheme and the master enable. It also holds two sticky fault flags, one for NMI and one for address error. A hardware event pulse sets each flag, and software can only clear them. Two schemes are fixed orders. The other two rotate: the channel that has just finished drops to the bottom of the order. No interface in the block carries a data stream. Request, grant and strobe are plain control pins. The grant acts as the only hold-off: while it is held, no other channel can be granted.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset, `reg_rdata` reads 0x0000 and `grant` is 0.
- R2: The control word has the mode field in bits 9:8, the master enable in bit 0, the NMI flag in bit 1 and the address-error flag in bit 2. Every other bit reads 0. Writing 0xFFFF from reset reads back 0x0301.
- R3: A one-cycle pulse on `nmi_evt` sets bit 1, and one on `err_evt` sets bit 2. A register write with a 0 in a flag's bit clears that flag, and a 1 leaves it unchanged. When an event and a clearing write fall in the same cycle, the flag ends up set.
- R4: No new grant is issued while bit 0 is 0, or while either flag is set.
- R5: With mode 00, the order is fixed: channel 0 first, then 3, then 2, then 1.
- R6: With mode 01, the order is fixed: channel 1 first, then 3, then 2, then 0.
- R7: Mode 10 rotates and starts from 0, 3, 2, 1. When a transfer completes, the finished channel moves to last place and the other channels keep their relative order.
- R8: Mode 11 rotates in the same way and starts from 3, 2, 1, 0.
- R9: A write that changes the mode field reloads the rotating order to the start order of the new mode. A write that keeps the same mode leaves the order untouched.
- R10: The grant is one-hot or zero. It appears on the clock edge that samples a request while the arbiter is idle, and it holds until the edge that samples `xfer_done`, which returns it to 0. A `xfer_done` pulse that arrives while no grant is held has no effect.
- R11: In the two fixed modes, a completed transfer does not change the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data for the control word |
| reg_rdata | output | 16 | Current value of the control word |
| req | input | 4 | Transfer request, one bit per channel |
| xfer_done | input | 1 | Transfer-complete strobe for the granted channel |
| nmi_evt | input | 1 | Pulse that sets the NMI flag |
| err_evt | input | 1 | Pulse that sets the address-error flag |
| grant | output | 4 | Registered one-hot grant |

## Verification
Most internal faults show up as a wrong winner. A corrupted rotating order, for example, makes the grant go to the wrong channel on the very next contested request with all four lines high. A lost or duplicated rotation step only becomes visible once the order has been walked through several completions. For that reason each rotating mode is run through every request pattern more than once, against an order model kept in the bench. Flag and enable faults appear within one cycle, either on `reg_rdata` or as a grant that should have been blocked.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int REG_W    = 16;
  localparam int MODE_LSB = 8;
  localparam int DME_BIT  = 0;
  localparam int NMI_BIT  = 1;
  localparam int AE_BIT   = 2;

  // channel id held at position pos (0 = highest) of the start order of a mode
  function automatic int base_order(input logic [1:0] mode, input int pos, input int n);
    int ch;
    case (mode)
      2'b01:   ch = (pos == 0) ? 1 : ((pos == n - 1) ? 0 : n - pos);
      2'b11:   ch = n - 1 - pos;
      default: ch = (pos == 0) ? 0 : n - pos;
    endcase
    return ch;
  endfunction
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             nmi_evt,
  input  logic             err_evt,
  output logic [REG_W-1:0] rdata,
  output logic [1:0]       mode,
  output logic             grant_ok,
  output logic             mode_load
);
  logic [1:0] mode_q;
  logic       dme_q, nmif_q, aef_q;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-1:MODE_LSB+2], wdata[MODE_LSB-1:AE_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      dme_q  <= 1'b0;
      nmif_q <= 1'b0;
      aef_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        mode_q <= wdata[MODE_LSB+1:MODE_LSB];
        dme_q  <= wdata[DME_BIT];
      end
      nmif_q <= nmi_evt | (nmif_q & ~(wr_en & ~wdata[NMI_BIT]));
      aef_q  <= err_evt | (aef_q & ~(wr_en & ~wdata[AE_BIT]));
    end
  end

  assign mode      = mode_q;
  assign grant_ok  = dme_q & ~nmif_q & ~aef_q;
  assign mode_load = wr_en && (wdata[MODE_LSB+1:MODE_LSB] != mode_q);

  always_comb begin
    rdata                        = '0;
    rdata[MODE_LSB+1:MODE_LSB]   = mode_q;
    rdata[DME_BIT]               = dme_q;
    rdata[NMI_BIT]               = nmif_q;
    rdata[AE_BIT]                = aef_q;
  end

  assert_nmi_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> rdata[NMI_BIT]);
  assert_err_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> rdata[AE_BIT]);
  assert_nmi_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[NMI_BIT] && !(wr_en && !wdata[NMI_BIT])) |=> rdata[NMI_BIT]);
  assert_ae_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[AE_BIT] && !(wr_en && !wdata[AE_BIT])) |=> rdata[AE_BIT]);
endmodule

// File: rtl/dma_arb_order.sv
module dma_arb_order
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    mode_load,
  input  logic [1:0]              mode_new,
  input  logic                    done_fire,
  input  logic [CW-1:0]           done_ch,
  output logic [NCH-1:0][CW-1:0]  order
);
  logic [NCH-1:0][CW-1:0] rot_q, rot_d, fixed_ord;
  logic                   hit;
  logic [NCH-1:0]         seen;

  for (genvar p = 0; p < NCH; p++) begin : g_fixed
    assign fixed_ord[p] = CW'(base_order(mode, p, NCH));
  end

  always_comb begin
    rot_d = rot_q;
    hit   = 1'b0;
    if (mode_load) begin
      for (int i = 0; i < NCH; i++) rot_d[i] = CW'(base_order(mode_new, i, NCH));
    end else if (done_fire && mode[1]) begin
      for (int i = 0; i < NCH - 1; i++) begin
        if (rot_q[i] == done_ch) hit = 1'b1;
        if (hit) rot_d[i] = rot_q[i+1];
      end
      rot_d[NCH-1] = done_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) rot_q[i] <= CW'(base_order(2'b00, i, NCH));
    end else begin
      rot_q <= rot_d;
    end
  end

  assign order = mode[1] ? rot_q : fixed_ord;

  always_comb begin
    seen = '0;
    for (int i = 0; i < NCH; i++) seen[rot_q[i]] = 1'b1;
  end

  assert_rot_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);
  assert_rot_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_fire && mode[1] && !mode_load) |=> (rot_q[NCH-1] == $past(done_ch)));
endmodule

// File: rtl/dma_arb_grant.sv
module dma_arb_grant #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grant_ok,
  input  logic [NCH-1:0]         req,
  input  logic [NCH-1:0][CW-1:0] order,
  input  logic                   xfer_done,
  output logic [NCH-1:0]         grant,
  output logic                   done_fire,
  output logic [CW-1:0]          done_ch
);
  logic [NCH-1:0] grant_q;
  logic           found, idle;
  logic [CW-1:0]  pick_ch;

  always_comb begin
    found   = 1'b0;
    pick_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[order[i]]) begin
        found   = 1'b1;
        pick_ch = order[i];
      end
    end
  end

  assign idle = (grant_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else if (idle) begin
      if (grant_ok && found) grant_q <= NCH'(1) << pick_ch;
    end else if (xfer_done) begin
      grant_q <= '0;
    end
  end

  always_comb begin
    done_ch = '0;
    for (int i = 0; i < NCH; i++) if (grant_q[i]) done_ch = CW'(i);
  end

  assign done_fire = !idle && xfer_done;
  assign grant     = grant_q;

  assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !xfer_done) |=> $stable(grant));
  assert_grant_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && !grant_ok) |=> (grant == '0));
  assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> (grant == '0 || (grant & $past(req)) != '0));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [NCH-1:0]   req,
  input  logic             xfer_done,
  input  logic             nmi_evt,
  input  logic             err_evt,
  output logic [NCH-1:0]   grant
);
  localparam int CW = $clog2(NCH);

  logic [1:0]             mode;
  logic                   grant_ok, mode_load, done_fire;
  logic [CW-1:0]          done_ch;
  logic [NCH-1:0][CW-1:0] order;

  dma_arb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .nmi_evt(nmi_evt), .err_evt(err_evt), .rdata(reg_rdata),
    .mode(mode), .grant_ok(grant_ok), .mode_load(mode_load)
  );

  dma_arb_order #(.NCH(NCH)) u_order (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_load(mode_load),
    .mode_new(reg_wdata[MODE_LSB+1:MODE_LSB]), .done_fire(done_fire),
    .done_ch(done_ch), .order(order)
  );

  dma_arb_grant #(.NCH(NCH)) u_grant (
    .clk(clk), .rst_n(rst_n), .grant_ok(grant_ok), .req(req), .order(order),
    .xfer_done(xfer_done), .grant(grant), .done_fire(done_fire), .done_ch(done_ch)
  );
endmodule

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  req = '0;
  logic        xfer_done = 1'b0;
  logic        nmi_evt = 1'b0;
  logic        err_evt = 1'b0;
  logic [3:0]  grant;

  int checks = 0;
  int failures = 0;
  int ord[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arb u_dma_prio_arb (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req(req), .xfer_done(xfer_done),
    .nmi_evt(nmi_evt), .err_evt(err_evt), .grant(grant)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_ord(input int a, input int b, input int c, input int d);
    ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
  endtask

  function automatic int pick(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (r[ord[i]]) return ord[i];
    return -1;
  endfunction

  task automatic rotate(input int ch);
    int p;
    p = 0;
    for (int i = 0; i < 4; i++) if (ord[i] == ch) p = i;
    for (int i = p; i < 3; i++) ord[i] = ord[i+1];
    ord[3] = ch;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr_en = 1'b1; reg_wdata = d;
    step();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic issue(input logic [3:0] r, input bit rot, input string tag);
    int exp;
    logic [3:0] eg;
    exp = pick(r);
    eg = 4'(1) << exp;
    req = r;
    step();
    chk(grant == eg, tag, grant, eg);
    req = '0;
    step();
    step();
    chk(grant == eg, "R10 hold", grant, eg);
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    chk(grant == 4'b0, "R10 release", grant, 0);
    if (rot) rotate(exp);
  endtask

  task automatic nogrant(input string tag);
    req = 4'hF;
    step();
    step();
    chk(grant == 4'b0, tag, grant, 0);
    req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(reg_rdata == 16'h0000, "R1 rdata", reg_rdata, 0);
    chk(grant == 4'b0, "R1 grant", grant, 0);

    wr(16'hFFFF);
    chk(reg_rdata == 16'h0301, "R2 readback", reg_rdata, 16'h0301);

    // R5: mode 00 sweep
    wr(16'h0001);
    chk(reg_rdata == 16'h0001, "R2 mode00", reg_rdata, 1);
    set_ord(0, 3, 2, 1);
    for (int p = 1; p < 16; p++) issue(4'(p), 1'b0, "R5 fixed 0>3>2>1");
    for (int p = 1; p < 16; p++) issue(4'(p), 1'b0, "R11 fixed order kept");

    // R6: mode 01 sweep
    wr(16'h0101);
    set_ord(1, 3, 2, 0);
    for (int p = 1; p < 16; p++) issue(4'(p), 1'b0, "R6 fixed 1>3>2>0");
    for (int p = 15; p > 0; p--) issue(4'(p), 1'b0, "R11 fixed order kept");

    // R7: mode 10 rotation
    wr(16'h0201);
    set_ord(0, 3, 2, 1);
    for (int k = 0; k < 2; k++)
      for (int p = 1; p < 16; p++) issue(4'(p), 1'b1, "R7 rotating");

    // R10: done while idle ignored
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
    issue(4'hF, 1'b1, "R10 idle done ignored");

    // R8: mode 11 rotation
    wr(16'h0301);
    set_ord(3, 2, 1, 0);
    issue(4'hF, 1'b1, "R8 start order");
    for (int k = 0; k < 2; k++)
      for (int p = 15; p > 0; p--) issue(4'(p), 1'b1, "R8 rotating");

    // R9: same-mode write keeps order, mode change reloads
    wr(16'h0301);
    issue(4'hF, 1'b1, "R9 same mode kept");
    issue(4'hF, 1'b1, "R9 same mode kept");
    wr(16'h0201);
    set_ord(0, 3, 2, 1);
    issue(4'hF, 1'b1, "R9 reload on change");
    wr(16'h0301);
    set_ord(3, 2, 1, 0);
    issue(4'hF, 1'b1, "R9 reload on change");

    // R4 / R3: enable and flags, in mode 00
    wr(16'h0000);
    set_ord(0, 3, 2, 1);
    chk(reg_rdata == 16'h0000, "R2 dme off", reg_rdata, 0);
    nogrant("R4 dme off");
    wr(16'h0001);
    nmi_evt = 1'b1;
    step();
    nmi_evt = 1'b0;
    chk(reg_rdata == 16'h0003, "R3 nmi set", reg_rdata, 3);
    nogrant("R4 nmi flag blocks");
    wr(16'h0003);
    chk(reg_rdata == 16'h0003, "R3 write one ignored", reg_rdata, 3);
    nogrant("R4 nmi flag blocks");
    wr(16'h0001);
    chk(reg_rdata == 16'h0001, "R3 nmi cleared", reg_rdata, 1);
    issue(4'hF, 1'b0, "R4 grant after clear");

    err_evt = 1'b1;
    step();
    err_evt = 1'b0;
    chk(reg_rdata == 16'h0005, "R3 ae set", reg_rdata, 5);
    nogrant("R4 ae flag blocks");
    wr(16'h0005);
    chk(reg_rdata == 16'h0005, "R3 write one ignored", reg_rdata, 5);
    wr(16'h0001);
    chk(reg_rdata == 16'h0001, "R3 ae cleared", reg_rdata, 1);

    reg_wr_en = 1'b1; reg_wdata = 16'h0001; nmi_evt = 1'b1;
    step();
    reg_wr_en = 1'b0; reg_wdata = '0; nmi_evt = 1'b0;
    chk(reg_rdata == 16'h0003, "R3 event beats clear", reg_rdata, 3);
    wr(16'h0001);
    issue(4'h6, 1'b0, "R5 after flags");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule